// File: doc/BRIEF.md
# Page-Register Address Translation Unit

This block sits between an 8-bit processor with a 16-bit logical address bus and a 256 KB physical memory. It holds sixteen 8-bit page registers, one for each 4 KB logical page. On every access the top four logical address bits pick a register. The low six bits of that register become the upper physical address bits, and the 12-bit page offset passes straight through.

The registers are loaded by processor writes into a window at the very top of the logical map. That area, the top 256 bytes, is never translated and always reads as ROM. Everywhere else, the page-level decode looks at the translated page number rather than the logical one. As a result, software can move the ROM half-page and the I/O page anywhere in the logical map. The I/O page is split further: one 256-byte group of 16-byte on-chip device slots, one group for an external peripheral bus, and RAM for the rest.

All outputs are combinational from the current access and the stored registers. A register write is taken on the clock edge that ends the write cycle.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, register k holds value k. Every logical address below $FF00 then maps to the physical address with the same low 16 bits and zeros in bits 17:16.
- R2: A write (rw = 0) with vma = 1 to logical address $FFF0 + k stores the write data into register k at the clock edge. The next access already uses the new value.
- R3: A read (rw = 1) in the window $FFF0-$FFFF leaves every register unchanged.
- R4: Outside $FF00-$FFFF, physical bits 17:12 equal bits 5:0 of the register chosen by logical bits 15:12. Register bits 7:6 have no effect. Physical bits 11:0 always equal logical bits 11:0.
- R5: For logical addresses $FF00-$FFFF, the ROM select is the only memory select. Physical bits 17:12 are all ones, whatever the register contents.
- R6: The register-window select is high only for $FFF0-$FFFF with vma = 1. A write elsewhere in $FF00-$FFEF changes no register.
- R7: When the translated page nibble (register bits 3:0) is $F, logical bit 11 = 1 selects ROM and logical bit 11 = 0 selects RAM.
- R8: When the translated page nibble is $E, logical bits 10:8 decide the select. A value of 000 selects an on-chip device, and the device slot output carries logical bits 7:4. A value of 001 selects the external peripheral bus. Any other value selects RAM. The device slot output is 0 whenever the device select is low.
- R9: Any other translated page nibble selects RAM. At most one of the RAM, ROM, device and external selects is high at a time.
- R10: With vma = 0 every select is low and no register is written.
- R11: The page decode follows the translated nibble, not logical bits 15:12. A logical page mapped to $E decodes as I/O, and logical page $E remapped elsewhere decodes as RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the identity mapping |
| vma | input | 1 | Valid memory access qualifier |
| rw | input | 1 | 1 = read, 0 = write |
| laddr | input | 16 | Logical address |
| wdata | input | 8 | Write data from the processor |
| paddr | output | 18 | Physical address |
| cs_ram | output | 1 | RAM select |
| cs_rom | output | 1 | ROM select |
| cs_dev | output | 1 | On-chip device group select |
| dev_slot | output | 4 | Device slot index (logical bits 7:4) |
| cs_ext | output | 1 | External peripheral bus select |
| cs_regs | output | 1 | Page-register window select |

## Verification
The physical address and all selects are combinational, so they are due in the same cycle as the access. The bench drives each access just after a falling edge and samples one nanosecond later. A register write becomes visible only after the next rising edge. The bench therefore issues the following access at the next falling edge and checks that it already sees the new mapping. The "has no effect" cases (a window read, a write with vma low, a write below the window) are each followed by an access through the affected page, so that a stray update would show up on paddr.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    parameter int LA_W      = 16;  // logical address width
    parameter int PG_IDX_W  = 4;   // logical page index bits
    parameter int PG_REG_W  = 8;   // page register width
    parameter int PHYS_PG_W = 6;   // physical page bits used
    parameter int BYP_W     = 8;   // top bits that mark the bypass area
    parameter int SLOT_W    = 4;   // device slot index bits
    parameter int SLOT_LO   = 4;   // 16-byte slots
    parameter int IO_GRP_W  = 3;   // 256-byte group select bits

    localparam int NUM_PG    = 1 << PG_IDX_W;
    localparam int OFF_W     = LA_W - PG_IDX_W;
    localparam int PA_W      = OFF_W + PHYS_PG_W;
    localparam int IO_GRP_LO = SLOT_LO + SLOT_W;
    localparam int NIB_W     = 4;
    localparam logic [NIB_W-1:0] PG_ROM = 4'hF;
    localparam logic [NIB_W-1:0] PG_IO  = 4'hE;

    typedef logic [PG_REG_W-1:0] pg_reg_t;

    typedef struct packed {
        pg_reg_t [NUM_PG-1:0] pg;
    } pg_file_t;

    typedef struct packed {
        logic              ram;
        logic              rom;
        logic              dev;
        logic              ext;
        logic              regs;
        logic              bypass;
        logic [SLOT_W-1:0] slot;
    } sel_t;
endpackage

// File: rtl/pxu_regfile.sv
module pxu_regfile
    import pxu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [PG_IDX_W-1:0] wr_idx,
    input  pg_reg_t             wr_data,
    input  logic [PG_IDX_W-1:0] rd_idx,
    output pg_reg_t             rd_page
);
    pg_file_t file_d, file_q;

    always_comb begin
        file_d = file_q;
        if (we) begin
            file_d.pg[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PG; i++) begin
                file_q.pg[i] <= pg_reg_t'(i);
            end
        end else begin
            file_q <= file_d;
        end
    end

    assign rd_page = file_q.pg[rd_idx];

    // R2: a write lands in the addressed register by the following cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(we) |-> file_q.pg[$past(wr_idx)] == $past(wr_data));

    // R3 / R10: without a write strobe the file holds its contents
    p_hold_no_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(we) |-> file_q == $past(file_q));
endmodule

// File: rtl/pxu_decode.sv
module pxu_decode
    import pxu_pkg::*;
(
    input  logic             vma,
    input  logic [LA_W-1:0]  laddr,
    input  logic [NIB_W-1:0] page_nib,
    output sel_t             sel
);
    always_comb begin
        sel = '0;
        if (laddr[LA_W-1 -: BYP_W] == {BYP_W{1'b1}}) begin
            sel.bypass = 1'b1;
            sel.rom    = vma;
            sel.regs   = vma && (laddr[LA_W-1:PG_IDX_W] == {(LA_W-PG_IDX_W){1'b1}});
        end else begin
            unique case (page_nib)
                PG_ROM: begin
                    sel.rom = vma && laddr[OFF_W-1];
                    sel.ram = vma && !laddr[OFF_W-1];
                end
                PG_IO: begin
                    if (laddr[IO_GRP_LO +: IO_GRP_W] == IO_GRP_W'(0)) begin
                        sel.dev  = vma;
                        sel.slot = vma ? laddr[SLOT_LO +: SLOT_W] : '0;
                    end else if (laddr[IO_GRP_LO +: IO_GRP_W] == IO_GRP_W'(1)) begin
                        sel.ext = vma;
                    end else begin
                        sel.ram = vma;
                    end
                end
                default: sel.ram = vma;
            endcase
        end
    end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vma,
    input  logic              rw,
    input  logic [LA_W-1:0]   laddr,
    input  logic [7:0]        wdata,
    output logic [PA_W-1:0]   paddr,
    output logic              cs_ram,
    output logic              cs_rom,
    output logic              cs_dev,
    output logic [SLOT_W-1:0] dev_slot,
    output logic              cs_ext,
    output logic              cs_regs
);
    pg_reg_t rd_page;
    sel_t    sel;
    logic    we;
    logic    unused_hi;

    assign we = sel.regs && !rw;

    pxu_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .wr_idx  (laddr[PG_IDX_W-1:0]),
        .wr_data (wdata),
        .rd_idx  (laddr[LA_W-1 -: PG_IDX_W]),
        .rd_page (rd_page)
    );

    pxu_decode u_dec (
        .vma      (vma),
        .laddr    (laddr),
        .page_nib (rd_page[NIB_W-1:0]),
        .sel      (sel)
    );

    assign unused_hi = ^rd_page[PG_REG_W-1:PHYS_PG_W];

    always_comb begin
        if (sel.bypass) begin
            paddr = {{PHYS_PG_W{1'b1}}, laddr[OFF_W-1:0]};
        end else begin
            paddr = {rd_page[PHYS_PG_W-1:0], laddr[OFF_W-1:0]};
        end
    end

    assign cs_ram   = sel.ram;
    assign cs_rom   = sel.rom;
    assign cs_dev   = sel.dev;
    assign dev_slot = sel.slot;
    assign cs_ext   = sel.ext;
    assign cs_regs  = sel.regs;

    p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        paddr[OFF_W-1:0] == laddr[OFF_W-1:0]);

    p_bypass_rom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vma && (laddr[LA_W-1 -: BYP_W] == {BYP_W{1'b1}})
        |-> cs_rom && !cs_ram && paddr[PA_W-1:OFF_W] == {PHYS_PG_W{1'b1}});

    p_window_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_regs |-> vma && laddr[LA_W-1:PG_IDX_W] == {(LA_W-PG_IDX_W){1'b1}});

    p_dev_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_dev |-> laddr[IO_GRP_LO +: IO_GRP_W] == '0 && dev_slot == laddr[SLOT_LO +: SLOT_W]);

    p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_ram, cs_rom, cs_dev, cs_ext}));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vma |-> !cs_ram && !cs_rom && !cs_dev && !cs_ext && !cs_regs && dev_slot == '0);
endmodule

// File: tb/page_xlate_unit_test.sv
module page_xlate_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vma = 1'b0;
    logic        rw = 1'b1;
    logic [15:0] laddr = '0;
    logic [7:0]  wdata = '0;
    logic [17:0] paddr;
    logic        cs_ram, cs_rom, cs_dev, cs_ext, cs_regs;
    logic [3:0]  dev_slot;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_pg [16];
    bit done = 1'b0;

    page_xlate_unit uut (
        .clk(clk), .rst_n(rst_n), .vma(vma), .rw(rw), .laddr(laddr), .wdata(wdata),
        .paddr(paddr), .cs_ram(cs_ram), .cs_rom(cs_rom), .cs_dev(cs_dev),
        .dev_slot(dev_slot), .cs_ext(cs_ext), .cs_regs(cs_regs)
    );

    always #10 clk = ~clk;

    // expected {paddr, ram, rom, dev, slot, ext, regs} from the requirements
    function automatic logic [26:0] model(input logic v, input logic [15:0] a);
        logic [17:0] pa;
        logic ram, rom, dev, ext, regs;
        logic [3:0] slot, nib;
        ram = 0; rom = 0; dev = 0; ext = 0; regs = 0; slot = 0;
        if (a[15:8] == 8'hFF) begin
            pa = {6'h3F, a[11:0]};
            rom = v;
            regs = v && (a[7:4] == 4'hF);
        end else begin
            pa = {exp_pg[a[15:12]][5:0], a[11:0]};
            nib = exp_pg[a[15:12]][3:0];
            if (nib == 4'hF) begin
                rom = v && a[11];
                ram = v && !a[11];
            end else if (nib == 4'hE) begin
                if (a[10:8] == 3'd0) begin
                    dev = v; slot = v ? a[7:4] : 4'd0;
                end else if (a[10:8] == 3'd1) ext = v;
                else ram = v;
            end else ram = v;
        end
        return {pa, ram, rom, dev, slot, ext, regs};
    endfunction

    task automatic drive(input logic v, input logic r, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        vma = v; rw = r; laddr = a; wdata = d;
        #1;
    endtask

    task automatic check(input string req);
        logic [26:0] got, exp;
        got = {paddr, cs_ram, cs_rom, cs_dev, dev_slot, cs_ext, cs_regs};
        exp = model(vma, laddr);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s addr=%h got=%h exp=%h", req, laddr, got, exp);
        end
    endtask

    task automatic access(input string req, input logic v, input logic [15:0] a);
        drive(v, 1'b1, a, 8'h00);
        check(req);
    endtask

    task automatic write_reg(input string req, input logic [3:0] k, input logic [7:0] val);
        drive(1'b1, 1'b0, 16'hFFF0 | {12'd0, k}, val);
        check(req);
        @(posedge clk);
        exp_pg[k] = val;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 16; i++) exp_pg[i] = 8'(i);
        #1;
        check("R1 during reset");
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        access("R1", 1'b1, 16'h0000);
        access("R1", 1'b1, 16'h1234);
        access("R1", 1'b1, 16'h5ABC);
        access("R1", 1'b1, 16'hD00F);
        access("R1", 1'b1, 16'hE123);
    endtask

    task automatic t_write;
        write_reg("R2 window", 4'h3, 8'h2A);
        access("R2 R4", 1'b1, 16'h3456);
        write_reg("R2 window", 4'h5, 8'hC7);
        access("R4 upper bits ignored", 1'b1, 16'h5FFF);
    endtask

    task automatic t_read_window;
        drive(1'b1, 1'b1, 16'hFFF3, 8'h55);
        check("R3 window read");
        @(posedge clk);
        access("R3 mapping kept", 1'b1, 16'h3000);
    endtask

    task automatic t_vma_low;
        drive(1'b0, 1'b0, 16'hFFF4, 8'h11);
        check("R10 idle");
        @(posedge clk);
        access("R10 no write", 1'b1, 16'h4000);
        access("R10 idle decode", 1'b0, 16'hE000);
    endtask

    task automatic t_bypass;
        write_reg("R6 window", 4'hF, 8'h00);
        access("R5", 1'b1, 16'hFF00);
        access("R5", 1'b1, 16'hFF80);
        access("R5 R6", 1'b1, 16'hFFF7);
        access("R11 page F remapped", 1'b1, 16'hF800);
        access("R11 page F remapped", 1'b1, 16'hFEFF);
        drive(1'b1, 1'b0, 16'hFFEF, 8'h77);
        check("R6 below window");
        @(posedge clk);
        access("R6 no write", 1'b1, 16'hF123);
    endtask

    task automatic t_page_f;
        write_reg("R2 window", 4'h1, 8'h0F);
        access("R7 rom half", 1'b1, 16'h1800);
        access("R7 ram half", 1'b1, 16'h1000);
        access("R7 ram half", 1'b1, 16'h17FF);
    endtask

    task automatic t_io_page;
        write_reg("R2 window", 4'h2, 8'h3E);
        access("R8 slot0", 1'b1, 16'h2000);
        access("R8 slot5", 1'b1, 16'h2050);
        access("R8 slotF", 1'b1, 16'h20F7);
        access("R8 ext", 1'b1, 16'h2100);
        access("R8 ram", 1'b1, 16'h2200);
        access("R8 ram", 1'b1, 16'h2F00);
    endtask

    task automatic t_remap;
        write_reg("R2 window", 4'hE, 8'h02);
        access("R11 E to ram", 1'b1, 16'hE000);
        access("R11 E to ram", 1'b1, 16'hE100);
        write_reg("R2 window", 4'h9, 8'h35);
        access("R9 ram", 1'b1, 16'h9ABC);
        access("R9 ram", 1'b1, 16'h0FFF);
    endtask

    initial begin
        t_reset();
        t_write();
        t_read_window();
        t_vma_low();
        t_bypass();
        t_page_f();
        t_io_page();
        t_remap();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule